// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the configuration of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test-select code. Software or board logic can set the values two ways. A parallel port presents the feedback value and the output code on wide inputs together with an active-low load strobe. A three-wire serial port (serial clock, serial data, serial load strobe) shifts a 14-bit word into a shift register and then transfers it to the configuration outputs.

All port inputs are treated as asynchronous. They pass through a synchronizer clocked by the system clock, and every edge or level is then acted on inside that clock domain. So the "latches" behave as follows. A transparent phase is a phase in which the output register is reloaded on every clock. A capture edge is the last such reload before the strobe leaves its active level. The parallel path wins over the serial path. While the parallel strobe is low it also holds the test code at zero, because the parallel port has no test field.

Top module: `cfg_loader`

## Requirements
- R1: During and right after reset, `m_out`, `n_out`, `t_out` and `sdo` are all zero.
- R2: Each rising edge of `sck` shifts `sdi` into a 14-bit shift register. After 14 shifts and a serial load, the first three bits sent appear on `t_out`, the next two on `n_out` and the last nine on `m_out`, MSB first in each field (word bit 13 = first bit sent = `t_out[2]`, word bit 0 = last bit = `m_out[0]`).
- R3: While `sld` is high and `pld_n` is high, the outputs follow the shift register contents, including bits shifted in during that time.
- R4: After `sld` falls, the outputs keep the word captured at the falling edge even if further bits are shifted in.
- R5: While `pld_n` is low, `m_out` and `n_out` follow `pm` and `pn`, including changes made during that time.
- R6: After `pld_n` rises, changes on `pm` and `pn` have no effect on the outputs.
- R7: While `pld_n` is low, a high `sld` has no effect: the parallel values are on the outputs.
- R8: While `pld_n` is low, `t_out` is 000, even if a serial load had set it to a nonzero value before.
- R9: `sdo` shows the shift register MSB, which is the oldest bit still held: after 14 shifts it equals the first bit sent, and one more shift moves it to the second bit.
- R10: With `pld_n` high and `sld` low, the outputs hold their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control inputs |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial shift clock (asynchronous) |
| sdi | input | 1 | Serial data, sampled at the rising edge of `sck` |
| sld | input | 1 | Serial load strobe, active high |
| pld_n | input | 1 | Parallel load strobe, active low, has priority |
| pm | input | 9 | Parallel feedback divide value |
| pn | input | 2 | Parallel output divide code |
| m_out | output | 9 | Configured feedback divide value |
| n_out | output | 2 | Configured output divide code |
| t_out | output | 3 | Configured test-select code |
| sdo | output | 1 | Shift register serial output (MSB) |

## Verification
Random 14-bit serial words separate the three fields and catch any swapped or reversed bit order. Random parallel words, changed while the strobe is open and again after it closes, show the difference between transparent and captured behaviour. Directed sequences cover the remaining cases: overlapping strobes, shifting after capture, a nonzero test code before a parallel load, and a long idle period. These show priority, test-code forcing and hold. Counting shifts past 14 shows that the serial output is the oldest bit still held.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int T_W = 3;
  localparam int SR_W = T_W + N_W + M_W;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else if (i == 0) st[i] <= d;
        else st[i] <= st[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int SR_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sck_s,
  input  logic            sdi_s,
  output logic [SR_W-1:0] word,
  output logic            sdo
);
  logic sck_d;
  logic rise;

  assign rise = sck_s & ~sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      word  <= '0;
    end else begin
      sck_d <= sck_s;
      if (rise) word <= {word[SR_W-2:0], sdi_s};
    end
  end

  assign sdo = word[SR_W-1];

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_s && !sck_d) |=> (word[0] == $past(sdi_s)));

  // R9
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(sck_s && !sck_d) |=> $stable(word));
endmodule

// File: rtl/cfg_select.sv
module cfg_select
  import cfg_loader_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            par_act,
  input  logic            ser_act,
  input  logic [M_W-1:0]  pm_s,
  input  logic [N_W-1:0]  pn_s,
  input  logic [SR_W-1:0] word,
  output logic [M_W-1:0]  m_q,
  output logic [N_W-1:0]  n_q,
  output logic [T_W-1:0]  t_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (par_act) begin
      m_q <= pm_s;
      n_q <= pn_s;
      t_q <= '0;
    end else if (ser_act) begin
      t_q <= word[SR_W-1 -: T_W];
      n_q <= word[M_W +: N_W];
      m_q <= word[M_W-1:0];
    end
  end

  // R7
  par_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (par_act && ser_act) |=> (m_q == $past(pm_s) && n_q == $past(pn_s)));

  // R8
  t_zero_chk: assert property (@(posedge clk) disable iff (rst)
    par_act |=> (t_q == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_act && !ser_act) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q)));

  // R3
  ser_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_act && ser_act) |=> ({t_q, n_q, m_q} == $past(word)));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sck,
  input  logic           sdi,
  input  logic           sld,
  input  logic           pld_n,
  input  logic [M_W-1:0] pm,
  input  logic [N_W-1:0] pn,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           sdo
);
  localparam int IN_W = 4 + M_W + N_W;
  localparam logic [IN_W-1:0] IN_RST = {1'b0, 1'b0, 1'b0, 1'b1, {(M_W+N_W){1'b0}}};

  logic [IN_W-1:0] raw, syn;
  logic            sck_s, sdi_s, sld_s, pld_n_s;
  logic [M_W-1:0]  pm_s;
  logic [N_W-1:0]  pn_s;
  logic [SR_W-1:0] word;

  assign raw = {sck, sdi, sld, pld_n, pm, pn};
  assign {sck_s, sdi_s, sld_s, pld_n_s, pm_s, pn_s} = syn;

  cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  cfg_shifter #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst(rst), .sck_s(sck_s), .sdi_s(sdi_s), .word(word), .sdo(sdo)
  );

  cfg_select u_sel (
    .clk(clk), .rst(rst), .par_act(~pld_n_s), .ser_act(sld_s),
    .pm_s(pm_s), .pn_s(pn_s), .word(word),
    .m_q(m_out), .n_q(n_out), .t_q(t_out)
  );

  // R1
  reset_chk: assert property (@(posedge clk)
    rst |=> (m_out == '0 && n_out == '0 && t_out == '0 && sdo == 1'b0));
endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int PERIOD = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, sdi = 1'b0, sld = 1'b0, pld_n = 1'b1;
  logic [8:0] pm = '0;
  logic [1:0] pn = '0;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] t_out;
  logic sdo;

  int total = 0, bad = 0, cycles = 0;
  logic [13:0] model = '0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_loader uut (.clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .sld(sld), .pld_n(pld_n),
                  .pm(pm), .pn(pn), .m_out(m_out), .n_out(n_out), .t_out(t_out), .sdo(sdo));

  function automatic logic [13:0] pack_out(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic wait_clk(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    sdi = b; wait_clk(4);
    sck = 1'b1; wait_clk(4);
    sck = 1'b0; wait_clk(4);
    model = {model[12:0], b};
  endtask

  task automatic shift_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic ser_load();
    sld = 1'b1; wait_clk(SETTLE);
    sld = 1'b0; wait_clk(SETTLE);
  endtask

  function automatic logic [13:0] outs();
    return pack_out(t_out, n_out, m_out);
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [13:0] w, held;
    void'($urandom(32'd1234));
    wait_clk(4);
    chk("R1 reset outputs", {outs()}, 14'h0);
    chk("R1 reset sdo", {13'h0, sdo}, 14'h0);
    rst = 1'b0; wait_clk(SETTLE);
    chk("R1 after reset", outs(), 14'h0);

    // R2 random serial words
    for (int k = 0; k < 8; k++) begin
      w = 14'($urandom);
      shift_word(w);
      ser_load();
      chk("R2 serial fields", outs(), w);
      chk("R9 sdo first bit", {13'h0, sdo}, {13'h0, w[13]});
      shift_bit(1'b0);
      chk("R9 sdo second bit", {13'h0, sdo}, {13'h0, w[12]});
      chk("R4 hold after shift", outs(), w);
    end

    // R3 transparent while sld high
    w = 14'h2A5C; shift_word(w);
    sld = 1'b1; wait_clk(SETTLE);
    chk("R3 follow word", outs(), model);
    shift_bit(1'b1); shift_bit(1'b0); wait_clk(SETTLE);
    chk("R3 follow shifted", outs(), model);
    held = model;
    sld = 1'b0; wait_clk(SETTLE);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0); wait_clk(SETTLE);
    chk("R4 captured at fall", outs(), held);

    // R10 long idle
    wait_clk(500);
    chk("R10 idle hold", outs(), held);

    // R8 nonzero t then parallel load
    w = 14'h3FFF; shift_word(w); ser_load();
    chk("R2 all ones", outs(), w);
    for (int k = 0; k < 6; k++) begin
      pm = 9'($urandom); pn = 2'($urandom);
      pld_n = 1'b0; wait_clk(SETTLE);
      chk("R8 t zero, R5 follow", outs(), pack_out(3'b000, pn, pm));
      pm = 9'($urandom); pn = 2'($urandom); wait_clk(SETTLE);
      chk("R5 follow change", outs(), pack_out(3'b000, pn, pm));
      held = pack_out(3'b000, pn, pm);
      pld_n = 1'b1; wait_clk(SETTLE);
      pm = ~pm; pn = ~pn; wait_clk(SETTLE);
      chk("R6 ignore after rise", outs(), held);
    end

    // R7 priority: both strobes active
    w = 14'h1E3B; shift_word(w);
    pm = 9'h155; pn = 2'b10;
    pld_n = 1'b0; sld = 1'b1; wait_clk(SETTLE);
    chk("R7 parallel wins", outs(), pack_out(3'b000, 2'b10, 9'h155));
    sld = 1'b0; wait_clk(SETTLE);
    chk("R7 after sld fall", outs(), pack_out(3'b000, 2'b10, 9'h155));
    pld_n = 1'b1; wait_clk(SETTLE);
    ser_load();
    chk("R2 serial after release", outs(), w);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule